// File: doc/BRIEF.md
# Flow-Through Late-Write Synchronous SRAM

This block is a single-port synchronous memory whose commands and data can be issued on every clock cycle in any mix of reads and writes, with no idle cycles between them. A read presents its data in the cycle right after the edge that registers the address. A write registers its address on one edge and takes its data on the next recognized edge. The write's data slot therefore lands in the cycle that a read would use for its output, and read/write turnarounds cost nothing.

Each word holds four byte lanes. A lane is eight data bits plus one parity bit. The outside world drives a write-data bus and reads back an output bus with a drive-enable flag, which together model one shared bidirectional bus. A clock enable freezes the whole block. Three chip enables select the device. An advance/load input either starts a new access or continues the running one. In a continuation cycle the address port carries the next burst address, which a separate sequencer works out. An asynchronous output enable gates the bus drivers.

Top module: `sram_nbl_top`

## Requirements
- R1: While `cen_n` is high at a rising edge, no state changes. A pending write stays pending and completes with the data present at the next edge where `cen_n` is low. A read keeps presenting the same word.
- R2: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A load cycle with any other pattern deselects it, and the bus is not driven in the following cycle.
- R3: At an edge with `cen_n`=0, `adv_ld_n`=0 and the device selected, `we_n`=0 starts a write and `we_n`=1 starts a read, at the address on `addr`.
- R4: The write data (`wdata`, `wpar`) is captured at the first recognized edge after the write command edge, and that edge completes the write. A new read, write or deselect may be issued on that same edge.
- R5: After an edge that registers a read, `rdata`/`rpar` show the addressed word in that same cycle, and `bus_oe` is 1 while `oe_n` is 0.
- R6: `bws_n[i]` is active low and is registered with the command or advance cycle. It controls `wdata[8i+7:8i]` and `wpar[i]`. Lanes whose select is 1 keep their old contents.
- R7: Whatever `oe_n` does, `bus_oe` is 0 during the data cycle of a write and while the device is deselected.
- R8: While reset is asserted and after it is released, the device is deselected and `bus_oe` is 0 until a read is registered.
- R9: A continuation edge (`cen_n`=0, `adv_ld_n`=1) keeps the access type of the running access and ignores the chip enables and `we_n`. It uses `addr` as the next address. When the device is deselected, it stays deselected.
- R10: A read registered on the edge that completes a write to the same address returns the newly written lanes, merged with the unwritten ones.
- R11: `oe_n` acts without a clock. While it is 1, `bus_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Clock enable, active low |
| adv_ld_n | input | 1 | 0 = load new access, 1 = continue current access |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low, sampled on load cycles |
| bws_n | input | 4 | Byte-lane write selects, active low |
| addr | input | AW | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 32 | Write data from the shared bus |
| wpar | input | 4 | Write parity from the shared bus |
| rdata | output | 32 | Read data toward the shared bus |
| rpar | output | 4 | Read parity toward the shared bus |
| bus_oe | output | 1 | 1 while the block drives the shared bus |

## Verification
The bench targets the cases where the write slot and the read slot interact. One is a read of the very address whose write completes on the same edge: a design that updated the array one edge late would return stale bytes. Another is a write command followed by suspended cycles with junk on the bus: a design that captured data without the clock-enable qualifier would store the junk. Continuation cycles are driven with deselecting chip enables and a flipped `we_n`. A design that re-decoded them would drop the burst or turn a read into a write. Partial lane masks and an output enable toggled mid-cycle expose wrong lane mapping and any drive that waits for a clock edge.

// File: rtl/sram_nbl_pkg.sv
package sram_nbl_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  localparam int unsigned LANE_BITS = 8;
endpackage

// File: rtl/sram_nbl_decode.sv
module sram_nbl_decode
  import sram_nbl_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen_n,
  input  logic             adv_ld_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bws_n,
  input  logic [AW-1:0]    addr,
  output op_e              op_q,
  output logic [AW-1:0]    addr_q,
  output logic [LANES-1:0] bws_q
);
  op_e              op_d;
  logic [AW-1:0]    addr_d;
  logic [LANES-1:0] bws_d;
  logic             selected;
  logic             step_en;

  assign selected = ~ce1_n & ce2 & ~ce3_n;
  assign step_en  = ~cen_n;

  always_comb begin
    op_d   = op_q;
    addr_d = addr_q;
    bws_d  = bws_q;
    if (step_en) begin
      addr_d = addr;
      bws_d  = bws_n;
      if (!adv_ld_n) begin
        if (!selected)  op_d = OP_IDLE;
        else if (we_n)  op_d = OP_READ;
        else            op_d = OP_WRITE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      bws_q  <= '1;
    end else begin
      op_q   <= op_d;
      addr_q <= addr_d;
      bws_q  <= bws_d;
    end
  end
endmodule

// File: rtl/sram_nbl_array.sv
module sram_nbl_array
  import sram_nbl_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LANES = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned DW   = LANES * LANE_BITS
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [LANES-1:0] lane_we,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wpar,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rdata,
  output logic [LANES-1:0] rpar
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_BITS-1:0] mem_d [DEPTH];
    logic                 mem_p [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && lane_we[g]) begin
        mem_d[wr_addr] <= wdata[g*LANE_BITS +: LANE_BITS];
        mem_p[wr_addr] <= wpar[g];
      end
    end

    assign rdata[g*LANE_BITS +: LANE_BITS] = mem_d[rd_addr];
    assign rpar[g]                         = mem_p[rd_addr];
  end
endmodule

// File: rtl/sram_nbl_outctl.sv
module sram_nbl_outctl
  import sram_nbl_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned DW   = LANES * LANE_BITS
) (
  input  op_e              op_q,
  input  logic             oe_n,
  input  logic [DW-1:0]    arr_data,
  input  logic [LANES-1:0] arr_par,
  output logic [DW-1:0]    rdata,
  output logic [LANES-1:0] rpar,
  output logic             bus_oe
);
  logic reading;

  assign reading = (op_q == OP_READ);

  always_comb begin
    rdata  = reading ? arr_data : '0;
    rpar   = reading ? arr_par  : '0;
    bus_oe = reading & ~oe_n;
  end
endmodule

// File: rtl/sram_nbl_top.sv
module sram_nbl_top
  import sram_nbl_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LANES = 4,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned DW   = LANES * LANE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen_n,
  input  logic             adv_ld_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bws_n,
  input  logic [AW-1:0]    addr,
  input  logic             oe_n,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wpar,
  output logic [DW-1:0]    rdata,
  output logic [LANES-1:0] rpar,
  output logic             bus_oe
);
  op_e              op_q;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] bws_q;
  logic             wr_en;
  logic [DW-1:0]    arr_data;
  logic [LANES-1:0] arr_par;

  sram_nbl_decode #(.AW(AW), .LANES(LANES)) u_decode (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .adv_ld_n(adv_ld_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n),
    .bws_n(bws_n), .addr(addr),
    .op_q(op_q), .addr_q(addr_q), .bws_q(bws_q)
  );

  // the data slot of a registered write closes on the next recognized edge
  assign wr_en = ~cen_n & (op_q == OP_WRITE);

  sram_nbl_array #(.DEPTH(DEPTH), .LANES(LANES)) u_array (
    .clk(clk), .wr_en(wr_en), .lane_we(~bws_q), .wr_addr(addr_q),
    .wdata(wdata), .wpar(wpar), .rd_addr(addr_q),
    .rdata(arr_data), .rpar(arr_par)
  );

  sram_nbl_outctl #(.LANES(LANES)) u_outctl (
    .op_q(op_q), .oe_n(oe_n), .arr_data(arr_data), .arr_par(arr_par),
    .rdata(rdata), .rpar(rpar), .bus_oe(bus_oe)
  );
endmodule

// File: rtl/sram_nbl_chk.sv
module sram_nbl_chk #(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 4,
  parameter int unsigned DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cen_n,
  input logic             adv_ld_n,
  input logic             ce1_n,
  input logic             ce2,
  input logic             ce3_n,
  input logic             we_n,
  input logic             oe_n,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    rdata,
  input logic [LANES-1:0] rpar,
  input logic             bus_oe
);
  logic sel;
  assign sel = ~ce1_n & ce2 & ~ce3_n;

  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(rdata) && $stable(rpar))); // R1

  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld_n && !sel) |=> !bus_oe); // R2

  AST_WRITE_SLOT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld_n && sel && !we_n) |=> !bus_oe); // R7

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld_n && sel && we_n) |=> (oe_n || bus_oe)); // R5

  AST_RESET_HIZ: assert property (@(posedge clk)
    !rst_n |-> !bus_oe); // R8

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !bus_oe); // R11
endmodule

bind sram_nbl_top sram_nbl_chk #(.AW(AW), .LANES(LANES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .adv_ld_n(adv_ld_n),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .oe_n(oe_n),
  .addr(addr), .rdata(rdata), .rpar(rpar), .bus_oe(bus_oe)
);

// File: tb/tb_sram_nbl_top.sv
module tb_sram_nbl_top;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int LANES = 4;
  localparam int DW    = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic cen_n, adv_ld_n, ce1_n, ce2, ce3_n, we_n, oe_n;
  logic [LANES-1:0] bws_n;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    wdata;
  logic [LANES-1:0] wpar;
  logic [DW-1:0]    rdata;
  logic [LANES-1:0] rpar;
  logic             bus_oe;

  int errors = 0;
  int checks = 0;
  string cur_tag = "";

  logic [DW-1:0]    ref_d [DEPTH];
  logic [LANES-1:0] ref_p [DEPTH];
  int               m_op;   // 0 idle, 1 read, 2 write
  logic [AW-1:0]    m_addr;
  logic [LANES-1:0] m_bws;

  always #2 clk = ~clk;

  sram_nbl_top #(.DEPTH(DEPTH), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .adv_ld_n(adv_ld_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .bws_n(bws_n),
    .addr(addr), .oe_n(oe_n), .wdata(wdata), .wpar(wpar),
    .rdata(rdata), .rpar(rpar), .bus_oe(bus_oe)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end (actual hung, expected done)");
    report();
  end

  task automatic check_bus();
    logic  exp_oe;
    string tag;
    exp_oe = (m_op == 1) && !oe_n;
    if (cur_tag != "")      tag = cur_tag;
    else if (m_op == 2)     tag = "R7";
    else if (m_op == 0)     tag = "R2";
    else if (oe_n)          tag = "R11";
    else                    tag = "R5";
    checks++;
    if (bus_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s bus_oe actual=%b expected=%b", tag, bus_oe, exp_oe);
    end
    if (exp_oe) begin
      checks++;
      if (rdata !== ref_d[m_addr] || rpar !== ref_p[m_addr]) begin
        errors++;
        $display("FAIL %s data actual=%h/%h expected=%h/%h", tag,
                 rdata, rpar, ref_d[m_addr], ref_p[m_addr]);
      end
    end
  endtask

  task automatic drive(input logic cen, input logic adv, input logic [2:0] ce,
                       input logic we, input logic [3:0] bws, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [3:0] p, input logic oe);
    @(negedge clk);
    cen_n = cen; adv_ld_n = adv; {ce1_n, ce2, ce3_n} = ce; we_n = we;
    bws_n = bws; addr = a; wdata = d; wpar = p; oe_n = oe;
    #1 check_bus();
    @(posedge clk);
    if (!cen) begin
      if (m_op == 2) begin
        for (int b = 0; b < LANES; b++) begin
          if (!m_bws[b]) begin
            ref_d[m_addr][b*8 +: 8] = d[b*8 +: 8];
            ref_p[m_addr][b]        = p[b];
          end
        end
      end
      if (!adv) m_op = (ce != 3'b010) ? 0 : (we ? 1 : 2);
      m_addr = a;
      m_bws  = bws;
    end
  endtask

  localparam logic [2:0] SEL = 3'b010;

  initial begin
    logic [DW-1:0] rd;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; cen_n = 1'b0; adv_ld_n = 1'b0; ce1_n = 1'b1; ce2 = 1'b0;
    ce3_n = 1'b1; we_n = 1'b1; bws_n = '1; addr = '0; oe_n = 1'b0;
    wdata = '0; wpar = '0;
    m_op = 0; m_addr = '0; m_bws = '1;
    repeat (3) @(negedge clk);
    cur_tag = "R8";
    check_bus();
    #3 rst_n = 1'b1;
    drive(0, 0, 3'b110, 1, 4'hF, 0, 0, 0, 0);

    // fill every word with back-to-back writes (R3, R4)
    cur_tag = "R4";
    for (int i = 0; i <= DEPTH; i++) begin
      rd = $urandom;
      drive(0, 0, (i < DEPTH) ? SEL : 3'b110, 0, 4'h0, AW'(i), rd, 4'($urandom), 0);
    end

    // R3: plain read after fill
    cur_tag = "R3";
    drive(0, 0, SEL, 1, 4'hF, 5, 0, 0, 0);
    drive(0, 0, 3'b110, 1, 4'hF, 0, 0, 0, 0);

    // R10: write then read of the same word on the completing edge
    cur_tag = "R10";
    drive(0, 0, SEL, 0, 4'h0, 9, 0, 0, 0);
    drive(0, 0, SEL, 1, 4'hF, 9, 32'hCAFE_F00D, 4'hA, 0);
    drive(0, 0, 3'b110, 1, 4'hF, 0, 0, 0, 0);

    // R6: lanes 1 and 3 masked, then read back
    cur_tag = "R6";
    drive(0, 0, SEL, 0, 4'b1010, 9, 0, 0, 0);
    drive(0, 0, SEL, 1, 4'hF, 9, 32'h1122_3344, 4'h5, 0);
    drive(0, 0, SEL, 0, 4'b0111, 9, 0, 0, 0);
    drive(0, 0, SEL, 1, 4'hF, 9, 32'hAB00_0000, 4'h8, 0);
    drive(0, 0, 3'b110, 1, 4'hF, 0, 0, 0, 0);

    // R1: suspension during a read and across a pending write
    cur_tag = "R1";
    drive(0, 0, SEL, 1, 4'hF, 12, 0, 0, 0);
    repeat (3) drive(1, 0, 3'b110, 0, 4'h0, 20, 32'hDEAD_BEEF, 4'hF, 0);
    drive(0, 0, SEL, 0, 4'h0, 13, 0, 0, 0);
    repeat (2) drive(1, 0, SEL, 1, 4'hF, 30, 32'hBAD0_BAD0, 4'h0, 0);
    drive(0, 0, SEL, 1, 4'hF, 13, 32'h0BAD_CAFE, 4'h3, 0);
    drive(0, 0, 3'b110, 1, 4'hF, 0, 0, 0, 0);

    // R9: continuation ignores enables and we_n; idle stays idle
    cur_tag = "R9";
    drive(0, 0, SEL, 1, 4'hF, 20, 0, 0, 0);
    drive(0, 1, 3'b110, 0, 4'h0, 21, 0, 0, 0);
    drive(0, 1, 3'b101, 0, 4'h0, 22, 0, 0, 0);
    drive(0, 0, SEL, 0, 4'h0, 24, 0, 0, 0);
    drive(0, 1, 3'b110, 1, 4'h0, 25, 32'h0000_2424, 4'h1, 0);
    drive(0, 1, 3'b110, 1, 4'h0, 26, 32'h0000_2525, 4'h2, 0);
    drive(0, 0, 3'b110, 1, 4'hF, 0, 32'h0000_2626, 4'h4, 0);
    drive(0, 1, SEL, 1, 4'hF, 25, 0, 0, 0);
    drive(0, 0, SEL, 1, 4'hF, 24, 0, 0, 0);
    drive(0, 1, SEL, 1, 4'hF, 25, 0, 0, 0);
    drive(0, 1, SEL, 1, 4'hF, 26, 0, 0, 0);

    // R2: every non-selecting pattern deselects
    cur_tag = "R2";
    for (int c = 0; c < 8; c++) begin
      drive(0, 0, SEL, 1, 4'hF, 3, 0, 0, 0);
      drive(0, 0, 3'(c), 1, 4'hF, 4, 0, 0, 0);
    end

    // R11 and R7: output enable toggled, write slot with oe_n low
    cur_tag = "R11";
    drive(0, 0, SEL, 1, 4'hF, 7, 0, 0, 0);
    drive(0, 1, SEL, 1, 4'hF, 8, 0, 0, 1);
    drive(0, 1, SEL, 1, 4'hF, 9, 0, 0, 0);
    cur_tag = "R7";
    drive(0, 0, SEL, 0, 4'h0, 10, 0, 0, 0);
    drive(0, 0, 3'b110, 1, 4'hF, 0, 32'h7777_0000, 4'h7, 0);

    // mixed random traffic
    cur_tag = "";
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] ce;
      ce = ($urandom_range(9) < 8) ? SEL : 3'($urandom);
      drive(($urandom_range(9) == 0), ($urandom_range(3) == 0), ce,
            1'($urandom), 4'($urandom), AW'($urandom), $urandom, 4'($urandom),
            ($urandom_range(7) == 0));
    end
    drive(0, 0, 3'b110, 1, 4'hF, 0, 0, 0, 0);
    report();
  end
endmodule